// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer

The block is a down-counting timer with a counter and two companion registers, here called the A register and the B register. Two external pins feed it: pin A and pin B. A three-bit mode code picks one of three behaviours:

- **Pulse-width generation.** The counter is reloaded alternately from the A and B registers.
- **Event counting.** The counter steps down on edges of pin A.
- **Dual capture.** The counter runs freely and its value is latched into A on a chosen pin A edge and into B on a chosen pin B edge.

Two pending flags, one per interrupt line, report the events of the current mode. Software clears them through the control word.

Software reaches the counter, the A and B registers and the control word through a simple write port and a combinational read port. The same selector values apply to both ports.

Timer steps are gated by a low-power idle input. While idle is asserted, the timer keeps running only if both the high-speed enable and the idle-run enable are set.

Top module: `mm_timer`

## Requirements
- R1: After reset the counter, A register, B register and control word read 0, pin_a_out is 0, and irq_a and irq_b are 0.
- R2: Selector values are shared by writes and reads: 0 is the counter, 1 is the A register, 2 is the B register, 3 is the control word. The control word has the following layout:
  - bits 2:0: mode code
  - bit 3: run
  - bit 4: high-speed enable
  - bit 5: idle-run enable
  - bit 6 on read: pending A; on write, a 1 clears pending A
  - bit 7 on read: pending B; on write, a 1 clears pending B
  - all other bits read 0
- R3: With mode code 100 or 101 and run set, each tick decrements the counter. A tick at 0 instead reloads the counter, alternately from A and then from B, and a software counter write makes the next reload come from A. A reload from A sets pending A, and a reload from B sets pending B.
- R4: Mode code 101 inverts pin_a_out on every reload. Mode code 100 leaves pin_a_out unchanged.
- R5: Mode code 000 decrements the counter once per rising edge of pin A. Mode code 001 decrements it once per falling edge. Each edge takes effect at the third clock edge after the pin changes, because the pin passes through a two-stage synchroniser.
- R6: In event counting, a decrement from 0 wraps the counter to 0xFFFF and sets pending A. A rising edge of pin B sets pending B.
- R7: In capture modes the counter decrements every tick. The selected pin A edge copies the counter into A, and the selected pin B edge copies it into B. The edge selection by mode code is:

  | Mode code | Pin A edge | Pin B edge |
  |-----------|------------|------------|
  | 110       | rising     | rising     |
  | 011       | rising     | falling    |
  | 111       | falling    | rising     |
  | 010       | falling    | falling    |

  An edge of the other polarity captures nothing.
- R8: In capture modes, pending A is set by the selected pin A edge or by a counter wrap from 0 to 0xFFFF. Pending B is set by the selected pin B edge.
- R9: When a capture and a software write to the same register fall in one cycle, the captured counter value is stored.
- R10: While idle_i is 1, the counter moves only if the high-speed enable and the idle-run enable are both 1. Otherwise it holds its value.
- R11: Writing 1 to a clear bit drops that pending flag. A set event in the same cycle wins over the clear.
- R12: A software counter write takes priority over any decrement or reload in the same cycle, and the counter then holds the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register selector for writes |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 2 | Register selector for reads |
| rd_data | output | CNT_W | Read data (combinational) |
| idle_i | input | 1 | Low-power idle indication |
| pin_a_in | input | 1 | Pin A input (event count / capture A) |
| pin_b_in | input | 1 | Pin B input (capture B / event B) |
| pin_a_out | output | 1 | Pulse-width output |
| irq_a | output | 1 | Pending A flag |
| irq_b | output | 1 | Pending B flag |

## Verification
A pin capture and a software write to the same register can land on one clock edge. To provoke this, the bench drops pin A and then schedules a write to the A register exactly three edges later, which is the edge on which the synchronised capture lands. The bench then expects the captured counter value, not the written data. A second collision occurs when a software counter write meets a running decrement. This case is judged by reading the counter exactly ten ticks after the write.

// File: rtl/mm_timer_pkg.sv
`timescale 1ns/1ps
package mm_timer_pkg;

   localparam logic [1:0] SEL_CNT  = 2'd0;
   localparam logic [1:0] SEL_RA   = 2'd1;
   localparam logic [1:0] SEL_RB   = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

   localparam int CTRL_W      = 8;
   localparam int BIT_RUN     = 3;
   localparam int BIT_HS      = 4;
   localparam int BIT_IDLERUN = 5;
   localparam int BIT_PEND_A  = 6;
   localparam int BIT_PEND_B  = 7;

   typedef enum logic [2:0] {
      MD_EVT_RISE = 3'b000,
      MD_EVT_FALL = 3'b001,
      MD_CAP_FF   = 3'b010,
      MD_CAP_RF   = 3'b011,
      MD_PWM_HOLD = 3'b100,
      MD_PWM_TGL  = 3'b101,
      MD_CAP_RR   = 3'b110,
      MD_CAP_FR   = 3'b111
   } tmr_mode_e;

   typedef struct packed {
      logic pwm;
      logic toggle;
      logic evt;
      logic evt_fall;
      logic cap;
      logic cap_a_fall;
      logic cap_b_fall;
   } mode_dec_t;

   function automatic mode_dec_t decode_mode(input logic [2:0] code);
      mode_dec_t d;
      d = '0;
      case (code)
         MD_PWM_TGL:  begin d.pwm = 1'b1; d.toggle = 1'b1; end
         MD_PWM_HOLD: d.pwm = 1'b1;
         MD_EVT_RISE: d.evt = 1'b1;
         MD_EVT_FALL: begin d.evt = 1'b1; d.evt_fall = 1'b1; end
         MD_CAP_RR:   d.cap = 1'b1;
         MD_CAP_RF:   begin d.cap = 1'b1; d.cap_b_fall = 1'b1; end
         MD_CAP_FR:   begin d.cap = 1'b1; d.cap_a_fall = 1'b1; end
         MD_CAP_FF:   begin d.cap = 1'b1; d.cap_a_fall = 1'b1; d.cap_b_fall = 1'b1; end
         default:     d = '0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/mm_timer_edge.sv
`timescale 1ns/1ps
module mm_timer_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mm_timer_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         last_q <= sync_q[LAST];
      end
   end

   assign rise = sync_q[LAST] & ~last_q;
   assign fall = ~sync_q[LAST] & last_q;

   // One pulse per edge (R5)
   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
   assert_single_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/mm_timer_ctrl.sv
`timescale 1ns/1ps
module mm_timer_ctrl
   import mm_timer_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              idle_i,
   output logic [2:0]        mode_code,
   output mode_dec_t         mode_dec,
   output logic              run,
   output logic              hs_en,
   output logic              idle_run,
   output logic              tick_en,
   output logic              clr_a,
   output logic              clr_b
);
   logic ctrl_wr;

   assign ctrl_wr = wr_en && (wr_sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_code <= 3'b000;
         run       <= 1'b0;
         hs_en     <= 1'b0;
         idle_run  <= 1'b0;
      end else if (ctrl_wr) begin
         mode_code <= wr_data[2:0];
         run       <= wr_data[BIT_RUN];
         hs_en     <= wr_data[BIT_HS];
         idle_run  <= wr_data[BIT_IDLERUN];
      end
   end

   assign mode_dec = decode_mode(mode_code);
   assign clr_a    = ctrl_wr & wr_data[BIT_PEND_A];
   assign clr_b    = ctrl_wr & wr_data[BIT_PEND_B];
   assign tick_en  = run & (~idle_i | (hs_en & idle_run));

   // Stopped timer never ticks (R10)
   assert_stop_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !wr_data[BIT_RUN]) |=> !tick_en);

endmodule

// File: rtl/mm_timer_count.sv
`timescale 1ns/1ps
module mm_timer_count
   import mm_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  mode_dec_t        mode_dec,
   input  logic             wr_cnt,
   input  logic             wr_ra,
   input  logic             wr_rb,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             a_rise,
   input  logic             a_fall,
   input  logic             b_rise,
   input  logic             b_fall,
   input  logic             clr_a,
   input  logic             clr_b,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] ra,
   output logic [CNT_W-1:0] rb,
   output logic             pend_a,
   output logic             pend_b,
   output logic             pin_out
);
   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic phase_b;
   logic dec_pulse, at_zero, pwm_reload, wrap;
   logic cap_a, cap_b, set_a, set_b;
   logic evt_edge;

   assign evt_edge   = mode_dec.evt_fall ? a_fall : a_rise;
   assign dec_pulse  = tick_en & ((mode_dec.pwm | mode_dec.cap) | (mode_dec.evt & evt_edge));
   assign at_zero    = (cnt == '0);
   assign pwm_reload = mode_dec.pwm & dec_pulse & at_zero;
   assign wrap       = ~mode_dec.pwm & dec_pulse & at_zero;
   assign cap_a      = tick_en & mode_dec.cap & (mode_dec.cap_a_fall ? a_fall : a_rise);
   assign cap_b      = tick_en & mode_dec.cap & (mode_dec.cap_b_fall ? b_fall : b_rise);
   assign set_a      = (pwm_reload & ~phase_b) | wrap | cap_a;
   assign set_b      = (pwm_reload & phase_b) | (tick_en & mode_dec.evt & b_rise) | cap_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         phase_b <= 1'b0;
      end else begin
         if (wr_cnt) begin
            cnt     <= wr_data;
            phase_b <= 1'b0;
         end else if (pwm_reload) begin
            cnt     <= phase_b ? rb : ra;
            phase_b <= ~phase_b;
         end else if (dec_pulse) begin
            cnt     <= cnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ra <= '0;
         rb <= '0;
      end else begin
         if (cap_a)      ra <= cnt;
         else if (wr_ra) ra <= wr_data;
         if (cap_b)      rb <= cnt;
         else if (wr_rb) rb <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_a  <= 1'b0;
         pend_b  <= 1'b0;
         pin_out <= 1'b0;
      end else begin
         pend_a <= set_a | (pend_a & ~clr_a);
         pend_b <= set_b | (pend_b & ~clr_b);
         if (pwm_reload && mode_dec.toggle) pin_out <= ~pin_out;
      end
   end

   // Reload from A on first phase (R3)
   assert_pwm_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_reload && !wr_cnt && !phase_b) |=> (cnt == $past(ra)) && pend_a);
   // Wrap to all ones sets pending A (R6)
   assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !wr_cnt) |=> (cnt == ALL_ONES) && pend_a);
   // Capture beats write (R9)
   assert_capture_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_a && wr_ra) |=> ra == $past(cnt));
   // No tick, no movement (R10)
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !wr_cnt) |=> $stable(cnt));
   // Software write wins (R12)
   assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> cnt == $past(wr_data));

endmodule

// File: rtl/mm_timer.sv
`timescale 1ns/1ps
module mm_timer
   import mm_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_sel,
   output logic [CNT_W-1:0] rd_data,
   input  logic             idle_i,
   input  logic             pin_a_in,
   input  logic             pin_b_in,
   output logic             pin_a_out,
   output logic             irq_a,
   output logic             irq_b
);
   localparam int N_PINS = 2;

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("mm_timer: CNT_W must be at least CTRL_W");
      end
   endgenerate

   logic [N_PINS-1:0] pin_v, rise_v, fall_v;
   logic [2:0]        mode_code;
   mode_dec_t         mode_dec;
   logic              run, hs_en, idle_run, tick_en, clr_a, clr_b;
   logic [CNT_W-1:0]  cnt, ra, rb;
   logic [CTRL_W-1:0] ctrl_rd;

   assign pin_v = {pin_b_in, pin_a_in};

   generate
      for (genvar p = 0; p < N_PINS; p++) begin : g_pin
         mm_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_v[p]),
            .rise (rise_v[p]),
            .fall (fall_v[p])
         );
      end
   endgenerate

   mm_timer_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data[CTRL_W-1:0]),
      .idle_i   (idle_i),
      .mode_code(mode_code),
      .mode_dec (mode_dec),
      .run      (run),
      .hs_en    (hs_en),
      .idle_run (idle_run),
      .tick_en  (tick_en),
      .clr_a    (clr_a),
      .clr_b    (clr_b)
   );

   mm_timer_count #(.CNT_W(CNT_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .mode_dec(mode_dec),
      .wr_cnt  (wr_en && (wr_sel == SEL_CNT)),
      .wr_ra   (wr_en && (wr_sel == SEL_RA)),
      .wr_rb   (wr_en && (wr_sel == SEL_RB)),
      .wr_data (wr_data),
      .a_rise  (rise_v[0]),
      .a_fall  (fall_v[0]),
      .b_rise  (rise_v[1]),
      .b_fall  (fall_v[1]),
      .clr_a   (clr_a),
      .clr_b   (clr_b),
      .cnt     (cnt),
      .ra      (ra),
      .rb      (rb),
      .pend_a  (irq_a),
      .pend_b  (irq_b),
      .pin_out (pin_a_out)
   );

   assign ctrl_rd = {irq_b, irq_a, idle_run, hs_en, run, mode_code};

   always_comb begin
      case (rd_sel)
         SEL_CNT: rd_data = cnt;
         SEL_RA:  rd_data = ra;
         SEL_RB:  rd_data = rb;
         default: rd_data = {{(CNT_W-CTRL_W){1'b0}}, ctrl_rd};
      endcase
   end

   // Clear drops pending A when no set occurs (R11)
   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_a && !tick_en) |=> !irq_a);

endmodule

// File: tb/tb_mm_timer.sv
`timescale 1ns/1ps
module tb_mm_timer;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [1:0]  wr_sel;
   logic [15:0] wr_data;
   logic [1:0]  rd_sel;
   logic [15:0] rd_data;
   logic        idle_i, pin_a_in, pin_b_in;
   logic        pin_a_out, irq_a, irq_b;

   always #2.5 clk = ~clk;

   mm_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .idle_i(idle_i),
      .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
      .pin_a_out(pin_a_out), .irq_a(irq_a), .irq_b(irq_b)
   );

   typedef struct {
      int          sig;
      logic [15:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;

   // Monitor: pops one expected item per falling edge and compares
   always @(negedge clk) begin
      item_t       it;
      logic [15:0] act;
      if (q.size() > 0) begin
         it = q.pop_front();
         case (it.sig)
            0:       act = rd_data;
            1:       act = {15'd0, pin_a_out};
            2:       act = {15'd0, irq_a};
            default: act = {15'd0, irq_b};
         endcase
         n_chk++;
         if (act !== it.exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   // Driver: pushes an expected item and waits for the monitor
   task automatic chk(input int sig, input logic [1:0] sel, input logic [15:0] exp, input string tag);
      item_t it;
      rd_sel = sel;
      it.sig = sig;
      it.exp = exp;
      it.tag = tag;
      q.push_back(it);
      wait (q.size() == 0);
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] data);
      @(posedge clk);
      #1;
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   function automatic logic [15:0] cw(input logic [2:0] md, input logic rn, input logic hs,
                                      input logic ir, input logic clr);
      return {8'd0, clr, clr, ir, hs, rn, md};
   endfunction

   task automatic pulse_a();
      pin_a_in = 1'b1; cyc(3);
      pin_a_in = 1'b0; cyc(3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog (all requirements): actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; rd_sel = 2'd0;
      idle_i = 1'b0; pin_a_in = 1'b0; pin_b_in = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset state
      chk(0, 2'd0, 16'h0000, "R1 counter");
      chk(0, 2'd1, 16'h0000, "R1 A register");
      chk(0, 2'd2, 16'h0000, "R1 B register");
      chk(0, 2'd3, 16'h0000, "R1 control");
      chk(1, 2'd0, 16'h0000, "R1 pin_a_out");
      chk(2, 2'd0, 16'h0000, "R1 irq_a");
      chk(3, 2'd0, 16'h0000, "R1 irq_b");

      // R2 register access
      wr(2'd1, 16'hA5C3);
      wr(2'd2, 16'h3C5A);
      wr(2'd0, 16'h1234);
      wr(2'd3, 16'h0035);
      chk(0, 2'd1, 16'hA5C3, "R2 A readback");
      chk(0, 2'd2, 16'h3C5A, "R2 B readback");
      chk(0, 2'd0, 16'h1234, "R2 counter readback");
      chk(0, 2'd3, 16'h0035, "R2 control readback");

      // R4 pulse-width mode without toggle
      wr(2'd3, cw(3'b100, 0, 0, 0, 1));
      wr(2'd1, 16'd3);
      wr(2'd2, 16'd5);
      wr(2'd0, 16'd1);
      wr(2'd3, cw(3'b100, 1, 0, 0, 0));
      cyc(2);
      chk(2, 2'd0, 16'h0001, "R3 reload from A sets irq_a (no toggle)");
      chk(1, 2'd0, 16'h0000, "R4 mode 100 keeps pin_a_out");
      wr(2'd3, cw(3'b100, 0, 0, 0, 1));

      // R3 / R4 pulse-width mode with toggle
      wr(2'd3, cw(3'b101, 0, 0, 0, 1));
      wr(2'd0, 16'd2);
      wr(2'd3, cw(3'b101, 1, 0, 0, 0));
      cyc(2);
      chk(2, 2'd0, 16'h0000, "R3 irq_a not yet set before underflow");
      cyc(1);
      chk(2, 2'd0, 16'h0001, "R3 irq_a on reload from A");
      chk(1, 2'd0, 16'h0001, "R4 toggle on first reload");
      chk(3, 2'd0, 16'h0000, "R3 irq_b clear before B reload");
      cyc(2);
      chk(3, 2'd0, 16'h0001, "R3 irq_b on reload from B");
      chk(1, 2'd0, 16'h0000, "R4 toggle on second reload");
      wr(2'd3, cw(3'b101, 0, 0, 0, 0));
      chk(0, 2'd0, 16'd2, "R3 counter after B reload");

      // R5 / R6 event counting on rising pin A
      wr(2'd3, cw(3'b000, 0, 0, 0, 1));
      wr(2'd0, 16'd2);
      wr(2'd3, cw(3'b000, 1, 0, 0, 0));
      pulse_a();
      cyc(1);
      chk(0, 2'd0, 16'd1, "R5 one decrement per rising edge");
      pulse_a();
      pulse_a();
      cyc(4);
      chk(0, 2'd0, 16'hFFFF, "R6 wrap to all ones");
      chk(2, 2'd0, 16'h0001, "R6 irq_a on wrap");
      chk(3, 2'd0, 16'h0000, "R6 irq_b idle before pin B edge");
      pin_b_in = 1'b1; cyc(4); pin_b_in = 1'b0; cyc(4);
      chk(3, 2'd0, 16'h0001, "R6 irq_b on pin B rising edge");

      // R11 clearing pending flags
      wr(2'd3, cw(3'b000, 0, 0, 0, 1));
      chk(0, 2'd3, 16'h0000, "R11 pending flags cleared");

      // R5 event counting on falling pin A
      wr(2'd3, cw(3'b001, 0, 0, 0, 0));
      wr(2'd0, 16'd10);
      wr(2'd3, cw(3'b001, 1, 0, 0, 0));
      pulse_a();
      pulse_a();
      pin_a_in = 1'b1;
      cyc(4);
      chk(0, 2'd0, 16'd8, "R5 falling-edge count");
      wr(2'd3, cw(3'b001, 0, 0, 0, 0));
      pin_a_in = 1'b0;
      cyc(4);

      // R7 / R8 capture, rising A and rising B
      wr(2'd3, cw(3'b110, 0, 0, 0, 1));
      wr(2'd0, 16'd1000);
      wr(2'd3, cw(3'b110, 1, 0, 0, 0));
      cyc(5);
      pin_a_in = 1'b1;
      cyc(4);
      pin_b_in = 1'b1;
      cyc(4);
      chk(2, 2'd0, 16'h0001, "R8 irq_a on pin A capture");
      chk(3, 2'd0, 16'h0001, "R8 irq_b on pin B capture");
      wr(2'd3, cw(3'b110, 0, 0, 0, 1));
      chk(0, 2'd1, 16'd993, "R7 A capture value");
      chk(0, 2'd2, 16'd989, "R7 B capture value");

      // R9 capture vs write on the same edge, falling/falling mode
      wr(2'd3, cw(3'b010, 0, 0, 0, 1));
      wr(2'd0, 16'd500);
      wr(2'd3, cw(3'b010, 1, 0, 0, 0));
      pin_a_in = 1'b0;
      cyc(2);
      wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h1234;
      cyc(1);
      wr_en = 1'b0;
      cyc(2);
      pin_b_in = 1'b0;
      cyc(4);
      pin_a_in = 1'b1;
      cyc(5);
      chk(3, 2'd0, 16'h0001, "R8 irq_b on falling B capture");
      wr(2'd3, cw(3'b010, 0, 0, 0, 1));
      chk(0, 2'd1, 16'd498, "R9 capture wins over write; R7 rising A ignored");
      chk(0, 2'd2, 16'd493, "R7 falling B capture value");

      // R8 capture-mode underflow
      wr(2'd0, 16'd3);
      wr(2'd3, cw(3'b110, 1, 0, 0, 0));
      cyc(6);
      chk(2, 2'd0, 16'h0001, "R8 irq_a on capture-mode wrap");
      chk(3, 2'd0, 16'h0000, "R8 irq_b untouched without pin B edge");
      wr(2'd3, cw(3'b110, 0, 0, 0, 1));
      chk(0, 2'd1, 16'd498, "R7 A unchanged without selected edge");

      // R10 / R12 idle gating
      idle_i = 1'b1;
      wr(2'd3, cw(3'b110, 1, 0, 1, 0));
      wr(2'd0, 16'd100);
      cyc(10);
      chk(0, 2'd0, 16'd100, "R10 frozen in idle without high-speed enable");
      wr(2'd3, cw(3'b110, 1, 1, 1, 0));
      wr(2'd0, 16'd100);
      cyc(10);
      chk(0, 2'd0, 16'd90, "R10 R12 runs in idle with both enables");
      wr(2'd3, cw(3'b110, 1, 1, 0, 0));
      wr(2'd0, 16'd100);
      cyc(10);
      chk(0, 2'd0, 16'd100, "R10 frozen in idle without idle-run enable");
      idle_i = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule